// File: doc/BRIEF.md
# Switchable Video RAM Window Decoder

This block places a 2 KB character video RAM over the top of a 16-bit CPU memory space. A one-bit enable, held in an I/O control register, decides whether the overlay is active. While it is active, any CPU memory access at F000h or higher goes to the video RAM. In the same cycle, a combinational RAM-disable output shuts off all onboard system RAM. While the enable is clear, the window is dormant and main memory answers every address.

The video RAM has two ports. The CPU side uses it through the window for writes and registered reads. An independent, registered read port serves the display controller with an 11-bit character address. Only the low eleven CPU address bits index the RAM, so F800h–FFFFh is a mirror of F000h–F7FFh.

Top module: `vram_window_decoder`

## Requirements
- R1: After reset the window enable is 0, so `ramDisable` stays low for every `memAddr` and `memRdData` reads 00h.
- R2: An I/O write whose port address has 58h in its low 8 bits loads `ioWrData[0]` into the window enable from the next clock on (1 = enabled, 0 = disabled). Bits 7:1 of `ioWrData` have no effect.
- R3: I/O cycles with `ioWr` low, or with a low port byte other than 58h, leave the enable unchanged. The upper 8 bits of `ioAddr` are not decoded.
- R4: While enabled, `ramDisable` is high in the same cycle (combinationally, with no register) whenever `memReq` is high and `memAddr` >= F000h.
- R5: While enabled, an access below F000h, or a cycle with `memReq` low, keeps `ramDisable` low. A write below F000h leaves the video RAM unchanged.
- R6: While enabled, a CPU write (`memReq`=1, `memWr`=1) at `memAddr` >= F000h stores `memWrData` at video RAM index `memAddr[10:0]` on that clock edge.
- R7: A CPU window read (`memReq`=1, `memWr`=0, enabled, address >= F000h) returns the byte at index `memAddr[10:0]` on `memRdData` one clock later. F800h–FFFFh aliases F000h–F7FFh. Any cycle that is not a window read gives 00h on `memRdData` one clock later.
- R8: `dispData` shows the video RAM byte at `dispAddr` one clock after `dispAddr` is presented, whatever the CPU side is doing. When a CPU write and a display read hit the same index in one cycle, the display sees the old byte.
- R9: While disabled, CPU writes at F000h or above do not change the video RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioWr | input | 1 | I/O write cycle strobe |
| ioAddr | input | 16 | I/O port address (low 8 bits decoded) |
| ioWrData | input | 8 | I/O write data (bit 0 is the window enable) |
| memReq | input | 1 | CPU memory access in this cycle |
| memWr | input | 1 | 1 = write, 0 = read |
| memAddr | input | 16 | CPU memory address |
| memWrData | input | 8 | CPU write data |
| memRdData | output | 8 | Video RAM read data, one clock after the request |
| ramDisable | output | 1 | Combinational disable for all onboard system RAM |
| dispAddr | input | 11 | Display controller character address |
| dispData | output | 8 | Display read data, one clock after the address |

## Verification
The bench builds the block with its default parameters: a 16-bit CPU address, an 11-bit video RAM index, port 58h and base F000h. With these values the whole 65536-entry CPU address space can be swept for `ramDisable` in both enable states. All 2048 video RAM bytes can be written through the window and read back through the display port and through the mirrored upper half. Expected bytes come from an arithmetic pattern of the index, and the enable register is probed with near-miss port addresses, ignored data bits and upper port bytes that are not decoded.

// File: rtl/vwd_pkg.sv
package vwd_pkg;
  // strobes from the decode control to the RAM datapath
  typedef struct packed {
    logic vramWr;   // CPU write hits the window this cycle
    logic vramRd;   // CPU read hits the window this cycle
  } vwdStrobe_t;
endpackage

// File: rtl/vwd_control.sv
module vwd_control
  import vwd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IO_AW = 16,
  parameter int PORT_DEC_W = 8,
  parameter logic [PORT_DEC_W-1:0] CTRL_PORT = 8'h58,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'hF000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioWr,
  input  logic [IO_AW-1:0]  ioAddr,
  input  logic              ioEnBit,
  input  logic              memReq,
  input  logic              memWr,
  input  logic [ADDR_W-1:0] memAddr,
  output logic              winEnable,
  output logic              ramDisable,
  output vwdStrobe_t        strobe
);
  logic portHit;
  logic inWindow;
  logic winHit;
  logic unusedPortHigh;

  assign unusedPortHigh = ^ioAddr[IO_AW-1:PORT_DEC_W];
  assign portHit = ioWr && (ioAddr[PORT_DEC_W-1:0] == CTRL_PORT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winEnable <= 1'b0;
    end else if (portHit) begin
      winEnable <= ioEnBit;
    end
  end

  assign inWindow = (memAddr >= WIN_BASE);
  assign winHit = winEnable && memReq && inWindow;

  // no register on this path: main RAM must drop out in the same cycle
  assign ramDisable = winHit;

  always_comb begin
    strobe.vramWr = winHit && memWr;
    strobe.vramRd = winHit && !memWr;
  end
endmodule

// File: rtl/vwd_datapath.sv
module vwd_datapath
  import vwd_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int VRAM_AW = 11
) (
  input  logic               clk,
  input  logic               rstN,
  input  vwdStrobe_t         strobe,
  input  logic [VRAM_AW-1:0] cpuIdx,
  input  logic [DATA_W-1:0]  cpuWrData,
  output logic [DATA_W-1:0]  cpuRdData,
  input  logic [VRAM_AW-1:0] dispIdx,
  output logic [DATA_W-1:0]  dispRdData
);
  localparam int VRAM_DEPTH = 1 << VRAM_AW;

  logic [DATA_W-1:0] vram [VRAM_DEPTH];

  always_ff @(posedge clk) begin
    if (strobe.vramWr) begin
      vram[cpuIdx] <= cpuWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cpuRdData <= '0;
    end else if (strobe.vramRd) begin
      cpuRdData <= vram[cpuIdx];
    end else begin
      cpuRdData <= '0;
    end
  end

  // read-first: a same-cycle CPU write is seen one access later
  always_ff @(posedge clk) begin
    dispRdData <= vram[dispIdx];
  end
endmodule

// File: rtl/vram_window_decoder.sv
module vram_window_decoder
  import vwd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int IO_AW = 16,
  parameter int PORT_DEC_W = 8,
  parameter int VRAM_AW = 11,
  parameter logic [PORT_DEC_W-1:0] CTRL_PORT = 8'h58,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'hF000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ioWr,
  input  logic [IO_AW-1:0]   ioAddr,
  input  logic [DATA_W-1:0]  ioWrData,
  input  logic               memReq,
  input  logic               memWr,
  input  logic [ADDR_W-1:0]  memAddr,
  input  logic [DATA_W-1:0]  memWrData,
  output logic [DATA_W-1:0]  memRdData,
  output logic               ramDisable,
  input  logic [VRAM_AW-1:0] dispAddr,
  output logic [DATA_W-1:0]  dispData
);
  vwdStrobe_t strobe;
  logic winEnable;
  logic unusedIoData;

  assign unusedIoData = ^ioWrData[DATA_W-1:1];

  vwd_control #(
    .ADDR_W(ADDR_W), .IO_AW(IO_AW), .PORT_DEC_W(PORT_DEC_W),
    .CTRL_PORT(CTRL_PORT), .WIN_BASE(WIN_BASE)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .ioWr(ioWr), .ioAddr(ioAddr),
    .ioEnBit(ioWrData[0]), .memReq(memReq), .memWr(memWr),
    .memAddr(memAddr), .winEnable(winEnable), .ramDisable(ramDisable),
    .strobe(strobe)
  );

  vwd_datapath #(
    .DATA_W(DATA_W), .VRAM_AW(VRAM_AW)
  ) data_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cpuIdx(memAddr[VRAM_AW-1:0]), .cpuWrData(memWrData),
    .cpuRdData(memRdData), .dispIdx(dispAddr), .dispRdData(dispData)
  );
endmodule

// File: rtl/vwd_checker.sv
module vwd_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int IO_AW = 16,
  parameter int PORT_DEC_W = 8,
  parameter logic [PORT_DEC_W-1:0] CTRL_PORT = 8'h58,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'hF000
) (
  input logic              clk,
  input logic              rstN,
  input logic              ioWr,
  input logic [IO_AW-1:0]  ioAddr,
  input logic [DATA_W-1:0] ioWrData,
  input logic              memReq,
  input logic              memWr,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memRdData,
  input logic              ramDisable,
  input logic              winEnable
);
  // R2
  enable_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ioWr && ioAddr[PORT_DEC_W-1:0] == CTRL_PORT) |=> (winEnable == $past(ioWrData[0])));

  // R3
  enable_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ioWr && ioAddr[PORT_DEC_W-1:0] == CTRL_PORT) |=> $stable(winEnable));

  // R4
  window_disable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (winEnable && memReq && memAddr >= WIN_BASE) |-> ramDisable);

  // R5
  no_stray_disable_chk: assert property (@(posedge clk) disable iff (!rstN)
    ramDisable |-> (winEnable && memReq && memAddr >= WIN_BASE));

  // R7
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ramDisable && !memWr) |=> (memRdData == '0));
endmodule

bind vram_window_decoder vwd_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IO_AW(IO_AW), .PORT_DEC_W(PORT_DEC_W),
  .CTRL_PORT(CTRL_PORT), .WIN_BASE(WIN_BASE)
) chk_i (
  .clk(clk), .rstN(rstN), .ioWr(ioWr), .ioAddr(ioAddr), .ioWrData(ioWrData),
  .memReq(memReq), .memWr(memWr), .memAddr(memAddr), .memRdData(memRdData),
  .ramDisable(ramDisable), .winEnable(winEnable)
);

// File: tb/vram_window_decoder_tb_top.sv
module vram_window_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ioWr = 1'b0;
  logic [15:0] ioAddr = '0;
  logic [7:0]  ioWrData = '0;
  logic        memReq = 1'b0;
  logic        memWr = 1'b0;
  logic [15:0] memAddr = '0;
  logic [7:0]  memWrData = '0;
  logic [7:0]  memRdData;
  logic        ramDisable;
  logic [10:0] dispAddr = '0;
  logic [7:0]  dispData;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  vram_window_decoder dut_i (
    .clk(clk), .rstN(rstN), .ioWr(ioWr), .ioAddr(ioAddr), .ioWrData(ioWrData),
    .memReq(memReq), .memWr(memWr), .memAddr(memAddr), .memWrData(memWrData),
    .memRdData(memRdData), .ramDisable(ramDisable), .dispAddr(dispAddr),
    .dispData(dispData)
  );

  function automatic logic [7:0] pat(int i);
    return 8'((i * 7 + 3) & 255);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ioWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    ioWr = 1'b1; ioAddr = a; ioWrData = d;
    @(negedge clk);
    ioWr = 1'b0;
  endtask

  task automatic cpuWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    memReq = 1'b1; memWr = 1'b1; memAddr = a; memWrData = d;
    @(negedge clk);
    memReq = 1'b0; memWr = 1'b0;
  endtask

  task automatic cpuRead(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    memReq = 1'b1; memWr = 1'b0; memAddr = a;
    @(negedge clk);
    d = memRdData;
    memReq = 1'b0;
  endtask

  task automatic dispRead(input logic [10:0] a, output logic [7:0] d);
    @(negedge clk);
    dispAddr = a;
    @(negedge clk);
    d = dispData;
  endtask

  // probes ramDisable at F000h with a read request
  task automatic probeTop(output logic rd);
    @(negedge clk);
    memReq = 1'b1; memWr = 1'b0; memAddr = 16'hF000;
    #1 rd = ramDisable;
    @(negedge clk);
    memReq = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic rd;
    int sweepErr;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state, full sweep with window off
    memReq = 1'b1; memWr = 1'b0;
    sweepErr = 0;
    for (int a = 0; a < 65536; a++) begin
      memAddr = 16'(a);
      #1;
      if (ramDisable !== 1'b0) sweepErr++;
    end
    chk(sweepErr == 0, "R1 sweep ramDisable after reset", sweepErr, 0);
    memReq = 1'b0;
    cpuRead(16'hF123, d);
    chk(d === 8'h00, "R1 memRdData after reset", d, 0);

    // R2: bit 0 clear with other bits set keeps the window off
    ioWrite(16'h0058, 8'hFE);
    probeTop(rd);
    chk(rd === 1'b0, "R2 data bits 7:1 ignored", rd, 0);

    // R3: near-miss port and ioWr low
    ioWrite(16'h0059, 8'h01);
    probeTop(rd);
    chk(rd === 1'b0, "R3 port 59h ignored", rd, 0);
    @(negedge clk);
    ioWr = 1'b0; ioAddr = 16'h0058; ioWrData = 8'h01;
    repeat (2) @(negedge clk);
    probeTop(rd);
    chk(rd === 1'b0, "R3 ioWr low ignored", rd, 0);

    // R3/R2: upper port byte not decoded, enable set
    ioWrite(16'hA758, 8'h01);
    probeTop(rd);
    chk(rd === 1'b1, "R3 upper port byte ignored, enable set", rd, 1);

    // R4/R5: full sweep with window on
    memReq = 1'b1; memWr = 1'b0;
    sweepErr = 0;
    for (int a = 0; a < 65536; a++) begin
      memAddr = 16'(a);
      #1;
      if (ramDisable !== (a >= 61440)) sweepErr++;
    end
    chk(sweepErr == 0, "R4 sweep ramDisable enabled", sweepErr, 0);
    memReq = 1'b0; memAddr = 16'hF800;
    #1;
    chk(ramDisable === 1'b0, "R5 no request no disable", ramDisable, 0);
    memAddr = 16'hEFFF; memReq = 1'b1;
    #1;
    chk(ramDisable === 1'b0, "R5 EFFFh below window", ramDisable, 0);
    memReq = 1'b0;

    // R6: fill the whole RAM through the lower window half
    for (int i = 0; i < 2048; i++) cpuWrite(16'(16'hF000 + i), pat(i));

    // R8: display port sees every byte
    sweepErr = 0;
    for (int i = 0; i < 2048; i++) begin
      dispRead(11'(i), d);
      if (d !== pat(i)) sweepErr++;
    end
    chk(sweepErr == 0, "R8 R6 display readback of fill", sweepErr, 0);

    // R7: CPU reads through the mirrored upper half
    sweepErr = 0;
    for (int i = 0; i < 2048; i++) begin
      cpuRead(16'(16'hF800 + i), d);
      if (d !== pat(i)) sweepErr++;
    end
    chk(sweepErr == 0, "R7 mirror readback F800h-FFFFh", sweepErr, 0);

    // R6: write through mirror lands on aliased index
    cpuWrite(16'hFFFF, 8'h5A);
    cpuRead(16'hF7FF, d);
    chk(d === 8'h5A, "R6 mirror write FFFFh -> index 7FFh", d, 8'h5A);

    // R7: non-window read gives zero
    cpuRead(16'hE000, d);
    chk(d === 8'h00, "R7 read below window returns 00h", d, 0);

    // R5: write below window leaves RAM alone
    cpuWrite(16'hE000, 8'hC3);
    dispRead(11'd0, d);
    chk(d === pat(0), "R5 write E000h ignored", d, pat(0));

    // R8: same-cycle write and display read returns old byte
    @(negedge clk);
    dispAddr = 11'd10;
    memReq = 1'b1; memWr = 1'b1; memAddr = 16'hF00A; memWrData = 8'h99;
    @(negedge clk);
    memReq = 1'b0; memWr = 1'b0;
    chk(dispData === pat(10), "R8 read-first on collision", dispData, pat(10));
    @(negedge clk);
    chk(dispData === 8'h99, "R8 new byte next cycle", dispData, 8'h99);

    // R2: disable, R9: writes while off are lost
    ioWrite(16'h0158, 8'h02);
    probeTop(rd);
    chk(rd === 1'b0, "R2 enable cleared", rd, 0);
    cpuWrite(16'hF005, ~pat(5));
    dispRead(11'd5, d);
    chk(d === pat(5), "R9 write while disabled ignored", d, pat(5));
    cpuRead(16'hF005, d);
    chk(d === 8'h00, "R9 read while disabled returns 00h", d, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule